// File: doc/BRIEF.md
# Programmable Peripheral Clock Output Generator

This block derives four clock-like outputs from one fast reference clock. The reference `clk_i` runs at twice the oscillator rate, so each `clk_i` cycle is one oscillator half-period. All outputs are built by counting these half-periods, and every output is a registered level that changes on a rising edge of `clk_i`. This lets fractional ratios such as /1.5 and /7.5 come out of single-edge logic:

- `osc_o` is the oscillator itself.
- `core_clk_o` is the processor clock, either the oscillator or the oscillator halved.
- `clk1_o` and `clk2_o` are two gated peripheral clocks.

One 8-bit control register sets the ratios and the gating. Firmware reaches it through a simple read/write port. Bit 7 of the register is an activity flag. A pulse on `activity_i` sets it, and a read clears it. While it is set, `sleep_block_o` asks the power controller to stay awake.

Each output repeats a pattern of a whole number of half-periods. The high phase is the longer half when the count is odd. A new ratio is taken only when the current output period ends, so a change never shortens or stretches a phase already under way.

Top module: `clkout_gen`

## Requirements
- R1: While reset is held, the register reads 0x00 and all four outputs are low. After reset, `osc_o` is high in the cycle after the first `clk_i` edge and then toggles every cycle (period 2 half-periods).
- R2: Register bit 5 selects the core clock. At 0, `core_clk_o` has a period of 2 half-periods (1 high, 1 low). At 1, the period is 4 (2 high, 2 low).
- R3: Register bit 1 gates `clk1_o`. The cycle after the register holds 0 in bit 1, `clk1_o` is low. Once bit 1 holds 1, `clk1_o` starts one edge later with a full high phase.
- R4: The `clk1_o` pattern depends on bits 0 and 6:
  - bit 0 = 0 and bit 6 = 0 gives period 2 (1 high, 1 low), the buffered oscillator;
  - bit 0 = 1 gives period 4 (2 high, 2 low), the oscillator divided by 2;
  - bit 0 = 0 and bit 6 = 1 gives period 3 (2 high, 1 low), the oscillator divided by 1.5.
- R5: Bit 6 has no effect on `clk1_o` while bit 0 is 1; the period stays 4 (2 high, 2 low).
- R6: Register bit 4 gates `clk2_o` in the same way as R3 does for `clk1_o`.
- R7: Register bits 3:2 select the `clk2_o` pattern:
  - 00 gives period 15 (8 high, 7 low);
  - 01 gives period 12 (6 high, 6 low);
  - 10 gives period 24 (12 high, 12 low);
  - 11 gives period 20 (10 high, 10 low).
- R8: A change of any ratio select takes effect only at the end of the current output period. The period in progress completes with its old high and low lengths.
- R9: Bit 7 is set on the edge after an `activity_i` pulse. A read (`rd_en_i`) returns the current value, including bit 7, and clears bit 7 on that edge. When an activity pulse and a read fall in the same cycle, bit 7 ends set. A write never changes bit 7.
- R10: `sleep_block_o` is high exactly when register bit 7 is set.
- R11: A write stores `wr_data_i[6:0]` into bits 6:0, and `rd_data_o` shows the register contents at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, one cycle per oscillator half-period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe; clears the activity flag |
| rd_data_o | output | 8 | Register contents |
| activity_i | input | 1 | Activity pulse; sets the activity flag |
| osc_o | output | 1 | Oscillator output |
| core_clk_o | output | 1 | Selected core clock |
| clk1_o | output | 1 | Gated peripheral clock 1 |
| clk2_o | output | 1 | Gated peripheral clock 2 |
| sleep_block_o | output | 1 | High while the activity flag is set |

## Verification
Two cases can fall in the same cycle:

- **Flag set and clear.** The bench drives `activity_i` and `rd_en_i` in the same cycle. It expects the read to return the old flag and the flag to end set. The bench also covers a read alone, which clears the flag, and a write with bit 7 high, which must leave the flag alone.
- **Ratio change against the period in progress.** The bench rewrites the `clk2_o` divisor in the first cycle of a high phase. It then measures the run lengths that follow: the old high and low lengths must finish before the new ones appear.

Throughout, a behavioural model compares every output on every cycle.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  // control register layout, MSB first
  typedef struct packed {
    logic       act;        // 7: activity flag, read-clear
    logic       c1_frac;    // 6: clk1 /1.5 when c1_half = 0
    logic       core_half;  // 5: core clock /2
    logic       c2_en;      // 4
    logic [1:0] c2_sel;     // 3:2
    logic       c1_en;      // 1
    logic       c1_half;    // 0: clk1 /2
  } ctrl_t;

  localparam int NCH = 4;

  typedef enum int {
    CH_OSC  = 0,
    CH_CORE = 1,
    CH_C1   = 2,
    CH_C2   = 3
  } ch_e;

endpackage

// File: rtl/clkout_ctrl_reg.sv
module clkout_ctrl_reg
  import clkout_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  input  logic       activity_i,
  output ctrl_t      ctrl_o
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_en_i) begin
        ctrl_q.c1_frac   <= wr_data_i[6];
        ctrl_q.core_half <= wr_data_i[5];
        ctrl_q.c2_en     <= wr_data_i[4];
        ctrl_q.c2_sel    <= wr_data_i[3:2];
        ctrl_q.c1_en     <= wr_data_i[1];
        ctrl_q.c1_half   <= wr_data_i[0];
      end
      // set wins over read-clear
      if (activity_i)   ctrl_q.act <= 1'b1;
      else if (rd_en_i) ctrl_q.act <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/clkout_div_sel.sv
module clkout_div_sel
  import clkout_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int OSC_HP    = 2,
  parameter int HALF_HP   = 4,
  parameter int FRAC_HP   = 3,
  parameter int C2_HP_S0  = 15,
  parameter int C2_HP_S1  = 12,
  parameter int C2_HP_S2  = 24,
  parameter int C2_HP_S3  = 20
) (
  input  ctrl_t                        ctrl_i,
  output logic [NCH-1:0]               en_o,
  output logic [NCH-1:0][CNT_W-1:0]    per_o,
  output logic [NCH-1:0][CNT_W-1:0]    hi_o
);

  logic [NCH-1:0][CNT_W-1:0] per;

  always_comb begin
    per[CH_OSC]  = CNT_W'(OSC_HP);
    per[CH_CORE] = ctrl_i.core_half ? CNT_W'(HALF_HP) : CNT_W'(OSC_HP);
    if (ctrl_i.c1_half)      per[CH_C1] = CNT_W'(HALF_HP);
    else if (ctrl_i.c1_frac) per[CH_C1] = CNT_W'(FRAC_HP);
    else                     per[CH_C1] = CNT_W'(OSC_HP);
    unique case (ctrl_i.c2_sel)
      2'd0:    per[CH_C2] = CNT_W'(C2_HP_S0);
      2'd1:    per[CH_C2] = CNT_W'(C2_HP_S1);
      2'd2:    per[CH_C2] = CNT_W'(C2_HP_S2);
      default: per[CH_C2] = CNT_W'(C2_HP_S3);
    endcase
  end

  // odd periods give the extra half-period to the high phase
  for (genvar g = 0; g < NCH; g++) begin : g_hi
    logic [CNT_W:0] sum;
    assign sum      = {1'b0, per[g]} + 1'b1;
    assign hi_o[g]  = sum[CNT_W:1];
  end

  assign per_o        = per;
  assign en_o[CH_OSC]  = 1'b1;
  assign en_o[CH_CORE] = 1'b1;
  assign en_o[CH_C1]   = ctrl_i.c1_en;
  assign en_o[CH_C2]   = ctrl_i.c2_en;

endmodule

// File: rtl/clkout_phase_gen.sv
module clkout_phase_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             clk_o
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, per_q, hi_q;
  logic             wrap;

  assign wrap = (cnt_q == per_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      per_q <= CNT_W'(2);
      hi_q  <= CNT_W'(1);
    end else if (!en_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= 1'b1;
      // ratio is sampled only at a period boundary
      if (!run_q || wrap) begin
        cnt_q <= '0;
        per_q <= per_i;
        hi_q  <= hi_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clk_o = run_q & (cnt_q < hi_q);

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int OSC_HP   = 2,
  parameter int HALF_HP  = 4,
  parameter int FRAC_HP  = 3,
  parameter int C2_HP_S0 = 15,
  parameter int C2_HP_S1 = 12,
  parameter int C2_HP_S2 = 24,
  parameter int C2_HP_S3 = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o,
  input  logic       activity_i,
  output logic       osc_o,
  output logic       core_clk_o,
  output logic       clk1_o,
  output logic       clk2_o,
  output logic       sleep_block_o
);

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HP_MAX = max_of(max_of(max_of(OSC_HP, HALF_HP), max_of(FRAC_HP, C2_HP_S0)),
                                 max_of(max_of(C2_HP_S1, C2_HP_S2), C2_HP_S3));
  localparam int CNT_W  = $clog2(HP_MAX + 1);

  ctrl_t                     ctrl;
  logic [NCH-1:0]            en;
  logic [NCH-1:0][CNT_W-1:0] per, hi;
  logic [NCH-1:0]            clk_v;

  clkout_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .activity_i (activity_i),
    .ctrl_o     (ctrl)
  );

  clkout_div_sel #(
    .CNT_W    (CNT_W),
    .OSC_HP   (OSC_HP),
    .HALF_HP  (HALF_HP),
    .FRAC_HP  (FRAC_HP),
    .C2_HP_S0 (C2_HP_S0),
    .C2_HP_S1 (C2_HP_S1),
    .C2_HP_S2 (C2_HP_S2),
    .C2_HP_S3 (C2_HP_S3)
  ) u_sel (
    .ctrl_i (ctrl),
    .en_o   (en),
    .per_o  (per),
    .hi_o   (hi)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    clkout_phase_gen #(.CNT_W(CNT_W)) u_gen (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[g]),
      .per_i  (per[g]),
      .hi_i   (hi[g]),
      .clk_o  (clk_v[g])
    );
  end

  assign rd_data_o     = ctrl;
  assign sleep_block_o = ctrl.act;
  assign osc_o         = clk_v[CH_OSC];
  assign core_clk_o    = clk_v[CH_CORE];
  assign clk1_o        = clk_v[CH_C1];
  assign clk2_o        = clk_v[CH_C2];

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_en_i,
  input logic       activity_i,
  input logic [7:0] rd_data_o,
  input logic       osc_o,
  input logic       clk1_o,
  input logic       clk2_o
);

  logic [1:0] live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              live_q <= '0;
    else if (live_q != 2'd2)  live_q <= live_q + 1'b1;
  end

  AST_OSC_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q == 2'd2) |-> (osc_o != $past(osc_o))); // R1

  AST_CLK1_GATED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[1] |=> !clk1_o); // R3

  AST_CLK2_GATED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[4] |=> !clk2_o); // R6

  AST_ACT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_i |=> rd_data_o[7]); // R9

  AST_ACT_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !activity_i) |=> !rd_data_o[7]); // R9

endmodule

bind clkout_gen clkout_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .activity_i (activity_i),
  .rd_data_o  (rd_data_o),
  .osc_o      (osc_o),
  .clk1_o     (clk1_o),
  .clk2_o     (clk2_o)
);

// File: tb/clkout_gen_test.sv
`timescale 1ns/1ps
module clkout_gen_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic       activity_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       osc_o, core_clk_o, clk1_o, clk2_o, sleep_block_o;

  int  n_chk = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  done = 0;

  always #5 clk_i = ~clk_i;

  clkout_gen uut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .rd_en_i       (rd_en_i),
    .rd_data_o     (rd_data_o),
    .activity_i    (activity_i),
    .osc_o         (osc_o),
    .core_clk_o    (core_clk_o),
    .clk1_o        (clk1_o),
    .clk2_o        (clk2_o),
    .sleep_block_o (sleep_block_o)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_reg;
  int  hl [4];
  int  ll [4];
  bit  ex [4];

  function automatic int ref_per(input int ch, input logic [7:0] r);
    case (ch)
      0: return 2;
      1: return r[5] ? 4 : 2;
      2: return r[0] ? 4 : (r[6] ? 3 : 2);
      default: case (r[3:2])
        2'd0: return 15;
        2'd1: return 12;
        2'd2: return 24;
        default: return 20;
      endcase
    endcase
  endfunction

  function automatic int ref_hi(input int ch, input logic [7:0] r);
    case (ch)
      0: return 1;
      1: return r[5] ? 2 : 1;
      2: return r[0] ? 2 : (r[6] ? 2 : 1);
      default: case (r[3:2])
        2'd0: return 8;
        2'd1: return 6;
        2'd2: return 12;
        default: return 10;
      endcase
    endcase
  endfunction

  function automatic bit ref_en(input int ch, input logic [7:0] r);
    if (ch == 2) return r[1];
    if (ch == 3) return r[4];
    return 1'b1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reg = '0;
      for (int c = 0; c < 4; c++) begin hl[c] = 0; ll[c] = 0; ex[c] = 0; end
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (!ref_en(c, m_reg)) begin
          hl[c] = 0; ll[c] = 0; ex[c] = 0;
        end else begin
          if (hl[c] == 0 && ll[c] == 0) begin
            hl[c] = ref_hi(c, m_reg);
            ll[c] = ref_per(c, m_reg) - hl[c];
          end
          if (hl[c] > 0) begin ex[c] = 1; hl[c]--; end
          else           begin ex[c] = 0; ll[c]--; end
        end
      end
      if (wr_en_i) m_reg[6:0] = wr_data_i[6:0];
      if (activity_i)   m_reg[7] = 1'b1;
      else if (rd_en_i) m_reg[7] = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R1 osc_o",          osc_o,         ex[0]);
      chk("R2 core_clk_o",     core_clk_o,    ex[1]);
      chk("R4 clk1_o",         clk1_o,        ex[2]);
      chk("R7 clk2_o",         clk2_o,        ex[3]);
      chk("R10 sleep_block_o", sleep_block_o, m_reg[7]);
      chk("R11 rd_data_o",     rd_data_o,     m_reg);
    end
  end

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected<=100000", cyc);
      finish_up();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  function automatic logic sig(input int ch);
    case (ch)
      0: return osc_o;
      1: return core_clk_o;
      2: return clk1_o;
      default: return clk2_o;
    endcase
  endfunction

  task automatic run_len(input int ch, input logic lvl, output int n);
    n = 0;
    while (sig(ch) == lvl && n < 100) begin n++; @(negedge clk_i); end
  endtask

  // measure one full high run and the low run after it
  task automatic measure(input int ch, output int h, output int l);
    int skip;
    idle(30);
    run_len(ch, 1'b1, skip);
    run_len(ch, 1'b0, skip);
    run_len(ch, 1'b1, h);
    run_len(ch, 1'b0, l);
  endtask

  int h, l, n;

  initial begin
    // R1: reset state
    idle(3);
    chk("R1 reset rd_data_o", rd_data_o, 8'h00);
    chk("R1 reset outputs", {osc_o, core_clk_o, clk1_o, clk2_o}, 4'b0000);
    rst_ni = 1'b1;
    idle(4);

    // R2: core clock
    measure(1, h, l); chk("R2 core full hi", h, 1); chk("R2 core full lo", l, 1);
    wr(8'h20);
    measure(1, h, l); chk("R2 core half hi", h, 2); chk("R2 core half lo", l, 2);

    // R4: clk1 patterns
    wr(8'h02);
    measure(2, h, l); chk("R4 clk1 osc hi", h, 1); chk("R4 clk1 osc lo", l, 1);
    wr(8'h03);
    measure(2, h, l); chk("R4 clk1 /2 hi", h, 2); chk("R4 clk1 /2 lo", l, 2);
    wr(8'h42);
    measure(2, h, l); chk("R4 clk1 /1.5 hi", h, 2); chk("R4 clk1 /1.5 lo", l, 1);
    // R5: bit 6 ignored when bit 0 set
    wr(8'h43);
    measure(2, h, l); chk("R5 clk1 hi", h, 2); chk("R5 clk1 lo", l, 2);

    // R3: gating clk1
    wr(8'h40);
    idle(1);
    for (int i = 0; i < 6; i++) begin chk("R3 clk1 held low", clk1_o, 0); @(negedge clk_i); end

    // R7: clk2 divisors
    wr(8'h10); measure(3, h, l); chk("R7 sel0 hi", h, 8);  chk("R7 sel0 lo", l, 7);
    wr(8'h14); measure(3, h, l); chk("R7 sel1 hi", h, 6);  chk("R7 sel1 lo", l, 6);
    wr(8'h18); measure(3, h, l); chk("R7 sel2 hi", h, 12); chk("R7 sel2 lo", l, 12);
    wr(8'h1C); measure(3, h, l); chk("R7 sel3 hi", h, 10); chk("R7 sel3 lo", l, 10);

    // R6: gating clk2
    wr(8'h0C);
    idle(1);
    for (int i = 0; i < 6; i++) begin chk("R6 clk2 held low", clk2_o, 0); @(negedge clk_i); end

    // R8: divisor change during a period
    wr(8'h08);
    wr(8'h18);
    n = 0;
    while (!clk2_o && n < 50) begin n++; @(negedge clk_i); end
    h = 1; wr_en_i = 1'b1; wr_data_i = 8'h14;
    @(negedge clk_i); wr_en_i = 1'b0;
    while (clk2_o && h < 100) begin h++; @(negedge clk_i); end
    chk("R8 old high kept", h, 12);
    run_len(3, 1'b0, l); chk("R8 old low kept", l, 12);
    run_len(3, 1'b1, h); chk("R8 new high", h, 6);

    // R9/R10: activity flag
    chk("R9 flag clear", rd_data_o[7], 0);
    @(negedge clk_i); activity_i = 1'b1;
    @(negedge clk_i); activity_i = 1'b0;
    chk("R9 flag set", rd_data_o[7], 1);
    chk("R10 sleep block", sleep_block_o, 1);
    wr(8'h14);
    chk("R9 write keeps flag", rd_data_o[7], 1);
    @(negedge clk_i); rd_en_i = 1'b1; activity_i = 1'b1;
    chk("R9 read returns flag", rd_data_o[7], 1);
    @(negedge clk_i); rd_en_i = 1'b0; activity_i = 1'b0;
    chk("R9 set wins over read", rd_data_o[7], 1);
    @(negedge clk_i); rd_en_i = 1'b1;
    @(negedge clk_i); rd_en_i = 1'b0;
    chk("R9 read clears", rd_data_o[7], 0);
    chk("R10 sleep released", sleep_block_o, 0);
    wr(8'h80);
    chk("R9 write cannot set flag", rd_data_o[7], 0);

    // R11: register contents
    wr(8'h7F);
    chk("R11 readback", rd_data_o, 8'h7F);
    idle(40);
    wr(8'h00);
    chk("R11 readback zero", rd_data_o, 8'h00);
    idle(10);
    finish_up();
  end

endmodule